// File: doc/BRIEF.md
# Scrambler Mismatch State Extractor

A receiver whose demodulator got one or more seed bits wrong descrambles the whole frame with a stray pseudo-random sequence added to it. That sequence obeys the scrambler recurrence m[n] = m[n-4] XOR m[n-7] (polynomial 1 + D^4 + D^7). This block recovers the sequence after the fact. It runs one bit per accepted cycle. In the header region it takes three inputs: the raw bit from the PHY, the re-encoded FEC-corrected data bit, and the re-encoded error-pattern bit. XORing the three removes the data and the bit errors and leaves only the mismatch bit.

The first octet carries start-up errors from the self-synchronising filter, so the block skips it. It captures seven consecutive stripped bits at a known frame position. These bits give the full generator state at that position. The block then walks that state backwards through the inverse recurrence, the window position modulo 127 times, and reports the state at frame bit 0. In parallel, a forward copy of the generator keeps running from the window. Every payload bit leaves the block with the regenerated mismatch bit XORed in. The reported state is qualified only after the header FEC decoder has signalled success for the current frame.

Top module: `smx_extract`

## Requirements
- R1: After reset, `data_vld_o` and `state_vld_o` are 0 and `state_o` reads 0.
- R2: The mismatch bit at frame index i in the header region is `phy_i ^ rdat_i ^ err_i` for that bit.
- R3: Bits at frame indices below SKIP (default 8) have no effect on the recovered state or on the corrected payload.
- R4: The recovered state is taken from the stripped bits at indices SKIP to SKIP+6. `state_o` bit i equals the mismatch bit at frame index i, for i = 0..6.
- R5: The state is stepped back to index 0 with the inverse recurrence m[n-1] = m[n+6] XOR m[n+2], applied SKIP mod 127 times.
- R6: Each accepted bit at frame index >= HDR_BITS (default 384) produces `data_vld_o`=1 on the next cycle, with `data_o` = `phy_i` XOR m[index]. Header bits produce no output.
- R7: When the mismatch state is all zeros, the payload passes through unchanged.
- R8: `state_vld_o` rises only once `hdr_ok_i` has been seen since the current frame start and the back-step is complete. It drops on the cycle after a frame start.
- R9: Cycles with `bit_vld_i`=0 advance no index, produce no output, and their `sof_i` is ignored.
- R10: An accepted bit with `sof_i`=1 is frame index 0 and restarts capture and tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_vld_i | input | 1 | Bit accepted this cycle |
| sof_i | input | 1 | Accepted bit is frame index 0 |
| phy_i | input | 1 | Raw descrambled bit from the PHY |
| rdat_i | input | 1 | Re-encoded corrected data bit (header) |
| err_i | input | 1 | Re-encoded error-pattern bit (header) |
| hdr_ok_i | input | 1 | Header FEC decode succeeded |
| data_o | output | 1 | Corrected payload bit |
| data_vld_o | output | 1 | `data_o` valid |
| state_o | output | 7 | Mismatch state at frame index 0 |
| state_vld_o | output | 1 | `state_o` qualified |

## Verification
Frames are built from random seeds: a random non-zero seed, the all-zero seed, and the all-ones seed. Each frame carries random data and error strips in the header and random junk in the skipped octet. A wrong strip, a wrong window position, or a wrong back-step count therefore shows up as a wrong state, and never cancels out. One frame has random idle gaps, with stray frame-start pulses on the idle cycles, to separate index counting from cycle counting. The qualification flag is exercised three ways: the decode-success pulse arrives at frame start, arrives mid-payload, or never arrives. A frame start that follows a qualified frame is checked to clear the flag.

// File: rtl/smx_pkg.sv
package smx_pkg;
  localparam int unsigned SW     = 7;
  localparam int unsigned PERIOD = 127;
  typedef logic [SW-1:0] st_t;

  // inverse of m[n+7] = m[n+3] ^ m[n]; state bit i = m[n+i]
  function automatic st_t step_back(st_t s);
    return {s[SW-2:0], s[6] ^ s[2]};
  endfunction
endpackage

// File: rtl/smx_bitpos.sv
module smx_bitpos #(
  parameter int unsigned HDR_BITS = 384,
  parameter int unsigned SKIP     = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic sof_i,
  output logic win_o,
  output logic win_last_o,
  output logic pay_o
);
  localparam int unsigned IW = $clog2(HDR_BITS + 1);
  localparam logic [IW-1:0] HDR_L = IW'(HDR_BITS);
  localparam logic [IW-1:0] WLO_L = IW'(SKIP);
  localparam logic [IW-1:0] WHI_L = IW'(SKIP + 6);

  logic [IW-1:0] idx_q, cur;

  assign cur        = sof_i ? '0 : idx_q;
  assign win_o      = (cur >= WLO_L) && (cur <= WHI_L);
  assign win_last_o = (cur == WHI_L);
  assign pay_o      = (cur == HDR_L);

  // saturates at HDR_BITS: every later bit is payload
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        idx_q <= '0;
    else if (bit_vld_i) idx_q <= (cur == HDR_L) ? cur : cur + 1'b1;
  end
endmodule

// File: rtl/smx_tracker.sv
module smx_tracker
  import smx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_vld_i,
  input  logic sof_i,
  input  logic win_i,
  input  logic win_last_i,
  input  logic mbit_i,
  output logic act_o,
  output logic pred_o,
  output st_t  seed_o
);
  st_t  hist_q;   // hist_q[0] newest
  logic lock_q;

  assign act_o  = lock_q & ~sof_i;
  assign pred_o = hist_q[3] ^ hist_q[6];

  // state at window start: bit i = m[SKIP+i]
  always_comb begin
    seed_o[SW-1] = mbit_i;
    for (int i = 0; i < SW-1; i++) seed_o[i] = hist_q[SW-2-i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      lock_q <= 1'b0;
    end else if (bit_vld_i) begin
      if (act_o)      hist_q <= {hist_q[SW-2:0], pred_o};
      else if (win_i) hist_q <= {hist_q[SW-2:0], mbit_i};
      if (win_i && win_last_i) lock_q <= 1'b1;
      else if (sof_i)          lock_q <= 1'b0;
    end
  end
endmodule

// File: rtl/smx_backstep.sv
module smx_backstep
  import smx_pkg::*;
#(
  parameter int unsigned SKIP = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic load_i,
  input  st_t  seed_i,
  output st_t  st_o,
  output logic done_o
);
  localparam int unsigned BACK = SKIP % PERIOD;
  localparam int unsigned CW   = $clog2(PERIOD + 1);

  st_t          st_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;

  assign st_o   = st_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0; cnt_q <= '0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      if (busy_q) begin
        st_q  <= step_back(st_q);
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
      if (clr_i) begin
        busy_q <= 1'b0;
        done_q <= 1'b0;
      end
      if (load_i) begin
        st_q   <= seed_i;
        cnt_q  <= CW'(BACK);
        busy_q <= (BACK != 0);
        done_q <= (BACK == 0);
      end
    end
  end
endmodule

// File: rtl/smx_extract.sv
module smx_extract
  import smx_pkg::*;
#(
  parameter int unsigned HDR_BITS = 384,
  parameter int unsigned SKIP     = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_vld_i,
  input  logic          sof_i,
  input  logic          phy_i,
  input  logic          rdat_i,
  input  logic          err_i,
  input  logic          hdr_ok_i,
  output logic          data_o,
  output logic          data_vld_o,
  output logic [SW-1:0] state_o,
  output logic          state_vld_o
);
  logic win, win_last, pay, act, pred, done, ok_q, dvld_q, dat_q, clr;
  st_t  seed, st;

  assign clr = bit_vld_i & sof_i;

  smx_bitpos #(.HDR_BITS(HDR_BITS), .SKIP(SKIP)) u_pos (
    .clk_i, .rst_ni, .bit_vld_i, .sof_i,
    .win_o(win), .win_last_o(win_last), .pay_o(pay)
  );

  smx_tracker u_trk (
    .clk_i, .rst_ni, .bit_vld_i, .sof_i,
    .win_i(win), .win_last_i(win_last),
    .mbit_i(phy_i ^ rdat_i ^ err_i),
    .act_o(act), .pred_o(pred), .seed_o(seed)
  );

  smx_backstep #(.SKIP(SKIP)) u_bk (
    .clk_i, .rst_ni, .clr_i(clr),
    .load_i(bit_vld_i & win & win_last),
    .seed_i(seed), .st_o(st), .done_o(done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q <= 1'b0; dvld_q <= 1'b0; dat_q <= 1'b0;
    end else begin
      ok_q   <= hdr_ok_i | (ok_q & ~clr);
      dvld_q <= bit_vld_i & pay;
      if (bit_vld_i) dat_q <= phy_i ^ (act & pred);
    end
  end

  assign data_o      = dat_q;
  assign data_vld_o  = dvld_q;
  assign state_vld_o = ok_q & done;
  assign state_o     = state_vld_o ? st : '0;
endmodule

// File: rtl/smx_extract_chk.sv
module smx_extract_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_vld_i,
  input logic       sof_i,
  input logic       phy_i,
  input logic       data_o,
  input logic       data_vld_o,
  input logic [6:0] state_o,
  input logic       state_vld_o
);
  a_r9_no_out_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> !data_vld_o);
  a_r6_out_follows_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_vld_o |-> $past(bit_vld_i));
  a_r8_sof_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_vld_i && sof_i) |=> !state_vld_o);
  a_r4_state_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_vld_o && !(bit_vld_i && sof_i)) |=> $stable(state_o));
  a_r7_zero_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_vld_o && state_o == 7'd0 && bit_vld_i && !sof_i)
      |=> (!data_vld_o || data_o == $past(phy_i)));
  a_r1_idle_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !state_vld_o |-> state_o == 7'd0);
endmodule

bind smx_extract smx_extract_chk u_chk (
  .clk_i, .rst_ni, .bit_vld_i, .sof_i, .phy_i,
  .data_o, .data_vld_o, .state_o, .state_vld_o
);

// File: tb/sim_smx_extract.sv
`timescale 1ns/1ps
module sim_smx_extract;
  localparam int HDR = 384, SKIP = 8, PAY = 96;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic bv = 0, sof = 0, phy = 0, rd = 0, er = 0, ok = 0;
  logic data_o, data_vld_o, state_vld_o;
  logic [6:0] state_o;

  smx_extract #(.HDR_BITS(HDR), .SKIP(SKIP)) u0 (
    .clk_i(clk), .rst_ni, .bit_vld_i(bv), .sof_i(sof), .phy_i(phy),
    .rdat_i(rd), .err_i(er), .hdr_ok_i(ok),
    .data_o, .data_vld_o, .state_o, .state_vld_o
  );

  int n_vec = 0, n_bad = 0;
  bit mseq [0:HDR+PAY-1];
  bit exp_dv = 0, exp_d = 0, sv_known = 1, exp_sv = 0;
  logic [6:0] exp_st = '0;
  string cur_tag = "R6";

  task automatic check_out();
    n_vec++;
    if (data_vld_o !== exp_dv) begin
      n_bad++;
      $display("FAIL R6/R9 data_vld_o act=%0b exp=%0b", data_vld_o, exp_dv);
    end else if (exp_dv && data_o !== exp_d) begin
      n_bad++;
      $display("FAIL %s data_o act=%0b exp=%0b", cur_tag, data_o, exp_d);
    end
    if (sv_known) begin
      n_vec++;
      if (state_vld_o !== exp_sv) begin
        n_bad++;
        $display("FAIL R8 state_vld_o act=%0b exp=%0b", state_vld_o, exp_sv);
      end else if (exp_sv && state_o !== exp_st) begin
        n_bad++;
        $display("FAIL R2/R3/R4/R5 state_o act=%h exp=%h", state_o, exp_st);
      end
    end
  endtask

  task automatic cyc(input bit v, input bit s, input bit p, input bit r,
                     input bit e, input bit k, input bit edv, input bit ed);
    @(negedge clk);
    check_out();
    bv = v; sof = s; phy = p; rd = r; er = e; ok = k;
    exp_dv = edv; exp_d = ed;
  endtask

  // ok_at: -1 never, 0 with frame start, >0 payload offset
  task automatic frame(input logic [6:0] sd, input int ok_at,
                       input int gap_pct, input string tag);
    for (int j = 0; j < 7; j++) mseq[j] = sd[j];
    for (int j = 7; j < HDR+PAY; j++) mseq[j] = mseq[j-4] ^ mseq[j-7];
    cur_tag = tag;
    for (int i = 0; i < HDR+PAY; i++) begin
      bit r, e, p, pd, kk;
      while (gap_pct > 0 && int'($urandom % 100) < gap_pct)  // R9 idle
        cyc(0, 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2),
            1'($urandom % 2), 0, 0, 0);
      r = 1'($urandom % 2); e = 1'($urandom % 2); pd = 1'($urandom % 2);
      if (i < SKIP)     p = 1'($urandom % 2);        // R3 junk octet
      else if (i < HDR) p = mseq[i] ^ r ^ e;         // R2 strip
      else              p = pd ^ mseq[i];
      kk = (ok_at == 0 && i == 0) || (ok_at > 0 && i == HDR + ok_at);
      cyc(1, i == 0, p, r, e, kk, i >= HDR, pd);     // R10 sof restarts
      if (i == 0) begin
        exp_sv = 0; sv_known = (ok_at != 0);
      end
      if ((ok_at == 0 && i == HDR) || (kk && ok_at > 0)) begin
        sv_known = 1; exp_sv = 1; exp_st = sd;
      end
    end
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_vec++;
    if (data_vld_o !== 1'b0 || state_vld_o !== 1'b0 || state_o !== 7'd0) begin
      n_bad++;
      $display("FAIL R1 reset act=%0b%0b%h exp=000", data_vld_o, state_vld_o, state_o);
    end
    rst_ni = 1'b1;
    frame(7'h5a, 20, 0, "R6");
    frame(7'h00, 0, 0, "R7");
    frame(7'h13 | 7'($urandom % 128), 40, 30, "R6 R10");
    frame(7'h7f, -1, 0, "R6 R10");
    frame(7'h01, 5, 10, "R6 R10");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule